// File: doc/BRIEF.md
# Pipelined Carry-Save Tree Multiplier

This block multiplies two unsigned 16-bit operands and returns their full 32-bit product. For every bit of the second operand it forms one shifted copy of the first operand, or zero. A tree of 3:2 carry-save adders compresses these sixteen rows, level by level, into one sum row and one carry row. A single carry-lookahead adder then resolves the carries once and produces the final result.

A register bank follows every compression level and the final adder. A new operand pair can therefore enter on every clock, and each result leaves a fixed number of cycles later together with its valid flag. The surrounding logic presents operands with `in_valid` and collects results whenever `out_valid` is high. There is no stall path. Reset is asserted asynchronously and is released inside the block through a two-flop synchronizer.

Top module: `mul_csa_pipe`

## Requirements
- R1: When `out_valid` is high, `out_product` equals the unsigned product `in_a * in_b` of the operand pair that produced it, held as 32 bits with no truncation.
- R2: If `in_valid` is sampled high at a rising edge, `out_valid` is high after the 7th rising edge, counting the sampling edge as the first. The matching product is present in that same cycle.
- R3: Operand pairs accepted on consecutive edges produce results on consecutive cycles, in the order they were accepted.
- R4: A cycle where `in_valid` is low produces a cycle with `out_valid` low, 7 edges later. Gaps in the input stream are kept exactly as they are.
- R5: While `rst_n` is low, `out_valid` is low. Operations still in flight when reset asserts never appear at the output. After `rst_n` rises, the block accepts operands from the third rising edge onward.
- R6: The largest operands, 0xFFFF times 0xFFFF, give 0xFFFE0001.
- R7: A zero in either operand gives a product of zero.
- R8: Multiplying by one returns the other operand, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is to be multiplied |
| in_a | input | 16 | Multiplicand, unsigned |
| in_b | input | 16 | Multiplier, unsigned |
| out_valid | output | 1 | `out_product` holds a result this cycle |
| out_product | output | 32 | Unsigned product |

## Verification
Every result is due after the 7th rising edge, counting the edge that samples the operands as the first. The bench drives operands just after a falling edge. Into a slot 7 cycles ahead it writes the expected flag, the product and the requirement tag. A monitor on each falling edge then compares `out_valid` and `out_product` with the slot for the current cycle, so idle and bubble cycles are checked as strictly as busy ones. After a reset the slots are cleared, and the bench waits out the two-edge release before it issues new operands.

// File: rtl/mcsa_pkg.sv
package mcsa_pkg;

  // rows left after one 3:2 level: each full triple becomes two rows,
  // leftovers pass straight through
  function automatic int next_rows(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  // rows present at the input of level lvl
  function automatic int rows_at(input int n0, input int lvl);
    int n;
    n = n0;
    for (int i = 0; i < lvl; i++) n = next_rows(n);
    return n;
  endfunction

  // number of 3:2 levels needed to reach two rows
  function automatic int tree_levels(input int n0);
    int n;
    int l;
    n = n0;
    l = 0;
    while (n > 2) begin
      n = next_rows(n);
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/mul_pp_gen.sv
module mul_pp_gen #(
  parameter int A_W = 16,
  parameter int B_W = 16
) (
  input  logic [A_W-1:0]             a,
  input  logic [B_W-1:0]             b,
  output logic [B_W*(A_W+B_W)-1:0]   rows
);
  localparam int P_W = A_W + B_W;

  // row i: multiplicand gated by multiplier bit i, moved up i places
  for (genvar i = 0; i < B_W; i++) begin : g_row
    assign rows[i*P_W +: P_W] = ({{(P_W-A_W){1'b0}}, a} << i) & {P_W{b[i]}};
  end
endmodule

// File: rtl/mul_csa_level.sv
module mul_csa_level
  import mcsa_pkg::*;
#(
  parameter int W    = 32,
  parameter int N_IN = 16
) (
  input  logic                         clk,
  input  logic                         en,
  input  logic [N_IN*W-1:0]            rows_i,
  output logic [next_rows(N_IN)*W-1:0] rows_o
);
  localparam int N_GRP = N_IN / 3;
  localparam int N_REM = N_IN % 3;
  localparam int N_OUT = next_rows(N_IN);

  logic [N_OUT*W-1:0] rows_d;

  // full adders, one per triple; the carry row is weighted one bit up
  for (genvar j = 0; j < N_GRP; j++) begin : g_csa
    logic [W-1:0] x, y, z;
    assign x = rows_i[(3*j+0)*W +: W];
    assign y = rows_i[(3*j+1)*W +: W];
    assign z = rows_i[(3*j+2)*W +: W];
    assign rows_d[(2*j)*W   +: W] = x ^ y ^ z;
    assign rows_d[(2*j+1)*W +: W] = ((x & y) | (x & z) | (y & z)) << 1;
  end

  // rows that did not fill a triple go through untouched
  for (genvar r = 0; r < N_REM; r++) begin : g_pass
    assign rows_d[(2*N_GRP+r)*W +: W] = rows_i[(3*N_GRP+r)*W +: W];
  end

  always_ff @(posedge clk) begin
    if (en) rows_o <= rows_d;
  end
endmodule

// File: rtl/mul_cla_adder.sv
module mul_cla_adder #(
  parameter int W  = 32,
  parameter int GW = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  localparam int NG = W / GW;

  always_comb begin
    logic [W-1:0]  g, p, c;
    logic [NG-1:0] grp_g, grp_p, grp_c;
    logic          acc, term, cb;
    g = x & y;
    p = x ^ y;
    // group generate / propagate
    for (int k = 0; k < NG; k++) begin
      acc  = 1'b0;
      term = 1'b1;
      for (int t = 0; t < GW; t++) begin
        acc  = g[k*GW+t] | (p[k*GW+t] & acc);
        term = term & p[k*GW+t];
      end
      grp_g[k] = acc;
      grp_p[k] = term;
    end
    // second level: every group carry written as a flat sum of products
    for (int k = 0; k < NG; k++) begin
      acc = 1'b0;
      for (int j = 0; j < k; j++) begin
        term = grp_g[j];
        for (int m = j + 1; m < k; m++) term = term & grp_p[m];
        acc = acc | term;
      end
      grp_c[k] = acc;
    end
    // carries inside each group from the group carry-in
    for (int k = 0; k < NG; k++) begin
      cb = grp_c[k];
      for (int t = 0; t < GW; t++) begin
        c[k*GW+t] = cb;
        cb = g[k*GW+t] | (p[k*GW+t] & cb);
      end
    end
    s = p ^ c;
  end
endmodule

// File: rtl/mul_csa_pipe.sv
module mul_csa_pipe
  import mcsa_pkg::*;
#(
  parameter int A_W = 16,
  parameter int B_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [A_W-1:0]       in_a,
  input  logic [B_W-1:0]       in_b,
  output logic                 out_valid,
  output logic [A_W+B_W-1:0]   out_product
);
  localparam int P_W   = A_W + B_W;
  localparam int N_PP  = B_W;
  localparam int N_LEV = tree_levels(N_PP);
  localparam int LAT   = N_LEV + 1;

  // reset: asserted at once, released after two edges
  logic rst_meta_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  // valid travels beside the data
  logic [LAT-1:0] vld_d, vld_q;
  always_comb vld_d = {vld_q[LAT-2:0], in_valid};

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  logic [N_PP*P_W-1:0] pp_rows;
  mul_pp_gen #(.A_W(A_W), .B_W(B_W)) u_pp (
    .a    (in_a),
    .b    (in_b),
    .rows (pp_rows)
  );

  for (genvar l = 0; l < N_LEV; l++) begin : g_lvl
    localparam int NI = rows_at(N_PP, l);
    localparam int NO = rows_at(N_PP, l + 1);
    logic [NI*P_W-1:0] din;
    logic [NO*P_W-1:0] dout;
    logic              en;
    if (l == 0) begin : g_first
      assign din = pp_rows;
      assign en  = in_valid;
    end else begin : g_next
      assign din = g_lvl[l-1].dout;
      assign en  = vld_q[l-1];
    end
    mul_csa_level #(.W(P_W), .N_IN(NI)) u_csa (
      .clk    (clk),
      .en     (en),
      .rows_i (din),
      .rows_o (dout)
    );
  end

  logic [2*P_W-1:0] last_rows;
  logic [P_W-1:0]   sum_d, prod_q;
  assign last_rows = g_lvl[N_LEV-1].dout;

  mul_cla_adder #(.W(P_W), .GW(4)) u_cla (
    .x (last_rows[P_W-1:0]),
    .y (last_rows[2*P_W-1:P_W]),
    .s (sum_d)
  );

  always_ff @(posedge clk) begin
    if (vld_q[LAT-2]) prod_q <= sum_d;
  end

  assign out_valid   = vld_q[LAT-1];
  assign out_product = prod_q;
endmodule

// File: rtl/mul_csa_chk.sv
module mul_csa_chk #(
  parameter int A_W = 16,
  parameter int B_W = 16,
  parameter int LAT = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [A_W-1:0]       in_a,
  input logic [B_W-1:0]       in_b,
  input logic                 out_valid,
  input logic [A_W+B_W-1:0]   out_product
);
  localparam int P_W = A_W + B_W;

  logic [LAT-1:0] mv;
  logic [A_W-1:0] ma [LAT];
  logic [B_W-1:0] mb [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mv <= '0;
    else        mv <= {mv[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    ma[0] <= in_a;
    mb[0] <= in_b;
    for (int i = 1; i < LAT; i++) begin
      ma[i] <= ma[i-1];
      mb[i] <= mb[i-1];
    end
  end

  // R2 / R3: output valid follows the model delay line exactly
  p_valid_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == mv[LAT-1]);

  // R4: a bubble stays a bubble
  p_bubble_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mv[LAT-1] |-> !out_valid);

  // R1: product matches the pair issued LAT edges earlier
  p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_product == P_W'(ma[LAT-1]) * P_W'(mb[LAT-1])));

  p_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$isunknown(out_product));

  // R5: no result while held in reset
  p_quiet_in_reset_r5: assert property (@(posedge clk)
    !rst_n |-> !out_valid);
endmodule

bind mul_csa_pipe mul_csa_chk #(.A_W(A_W), .B_W(B_W), .LAT(LAT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .in_valid    (in_valid),
  .in_a        (in_a),
  .in_b        (in_b),
  .out_valid   (out_valid),
  .out_product (out_product)
);

// File: tb/tb_mul_csa_pipe.sv
module tb_mul_csa_pipe;
  localparam int LAT = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_a, in_b;
  logic        out_valid;
  logic [31:0] out_product;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 0;

  bit          exp_v   [64];
  logic [31:0] exp_p   [64];
  string       exp_tag [64];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mul_csa_pipe dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_product(out_product)
  );

  // result monitor: slot for this cycle was filled LAT cycles ago
  always @(negedge clk) begin
    if (mon_on) begin
      int i;
      i = cyc % 64;
      checks++;
      if (out_valid !== exp_v[i]) begin
        errors++;
        $display("FAIL %s cycle %0d: out_valid=%b expected %b",
                 exp_v[i] ? "R2" : "R4", cyc, out_valid, exp_v[i]);
      end else if (exp_v[i]) begin
        checks++;
        if (out_product !== exp_p[i]) begin
          errors++;
          $display("FAIL %s cycle %0d: product=%h expected %h",
                   exp_tag[i], cyc, out_product, exp_p[i]);
        end
      end
      exp_v[i] = 1'b0;
    end
  end

  task automatic issue(input logic [15:0] a, input logic [15:0] b, input string tag);
    int i;
    @(negedge clk);
    in_valid = 1'b1;
    in_a = a;
    in_b = b;
    i = (cyc + LAT) % 64;
    exp_v[i]   = 1'b1;
    exp_p[i]   = 32'(a) * 32'(b);
    exp_tag[i] = tag;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_a = 16'hDEAD;
    in_b = 16'hBEEF;
    exp_v[(cyc + LAT) % 64] = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < LAT + 3; k++) idle();
  endtask

  task automatic check_bit(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: out_valid=%b expected %b", tag, act, expv);
    end
  endtask

  // R5: reset state
  task automatic t_reset_state();
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_a = '0;
    in_b = '0;
    repeat (3) begin
      @(negedge clk);
      check_bit("R5", out_valid, 1'b0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;
    drain();
  endtask

  // R7: zero operands
  task automatic t_zero();
    issue(16'h0000, 16'h0000, "R7");
    issue(16'h0000, 16'hFFFF, "R7");
    issue(16'hFFFF, 16'h0000, "R7");
    drain();
  endtask

  // R6: largest operands
  task automatic t_max();
    issue(16'hFFFF, 16'hFFFF, "R6");
    issue(16'hFFFF, 16'h8000, "R6");
    drain();
  endtask

  // R8: identity
  task automatic t_one();
    issue(16'h0001, 16'hA5C3, "R8");
    issue(16'h7F01, 16'h0001, "R8");
    issue(16'h0001, 16'h0001, "R8");
    drain();
  endtask

  // R3 / R1: back-to-back random pairs
  task automatic t_stream();
    for (int k = 0; k < 48; k++) issue(16'($urandom), 16'($urandom), "R3");
    drain();
  endtask

  // R4: bubbles in the stream
  task automatic t_bubbles();
    for (int k = 0; k < 24; k++) begin
      if (k % 3 == 1) idle();
      else issue(16'($urandom), 16'($urandom), "R1");
    end
    drain();
  endtask

  // R5: reset with work in flight
  task automatic t_mid_reset();
    for (int k = 0; k < 4; k++) issue(16'($urandom), 16'($urandom), "R1");
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    for (int k = 0; k < 64; k++) exp_v[k] = 1'b0;
    #1 check_bit("R5", out_valid, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drain();
    issue(16'h1234, 16'h5678, "R5");
    drain();
  endtask

  initial begin
    for (int k = 0; k < 64; k++) exp_v[k] = 1'b0;
    t_reset_state();
    t_zero();
    t_max();
    t_one();
    t_stream();
    t_bubbles();
    t_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog: run still busy after 20000 cycles, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule